// File: doc/BRIEF.md
# Dual-Row Configuration Selector

This block keeps the configuration of a clock synthesizer and decides which stored copy drives the synthesizer datapath. Three copies exist. Two rows behave like write-once non-volatile cells: each row gains its valid flag when it is programmed and cannot be changed after that. The third copy is a volatile shadow register that can be rewritten without limit. Firmware or a test fixture uses the shadow register to adjust the feedback count, reference count, divider and tuning while it measures the output. When the result is right, it burns a row. That row then takes over.

Two straps fix the operating personality. When the frequency-select strap is low, the block works in reprogram mode: the second row, once burned, replaces the first row. When the strap is high, the two rows hold two alternate frequencies and a select pin picks between them. The control pin is then used as that select input, so the power-management fields are forced to zero. A separate strap disables the shadow register completely. Every decoded output is registered, and a code reports which copy is active.

Top module: `cfg_row_selector`

## Requirements
- R1: The configuration word is `wr_data` with these fields: feedback count in bits [11:0], reference count in [21:12], post-divider select in [24:22], divider source in [25], capacitor tuning in [32:26], duty level in [33], power-management mode in [34] and power-management timing in [35]. Each field appears unchanged on its own output port.
- R2: While no row is valid and `shadow_off` is low, the shadow copy is active (`active_src`=1). The shadow copy can be rewritten any number of times. Once a row is active, a shadow write has no effect on the outputs.
- R3: In reprogram mode (`fs_mode`=0), a valid row is active whenever one exists. Row 1 takes priority over row 0 (`active_src` 2 = row 0, 3 = row 1).
- R4: While `shadow_off` is high, the shadow copy is never active, and a shadow write has no effect on the outputs. Programmed rows still drive the outputs.
- R5: In reprogram mode, burning row 1 replaces the configuration of row 0 exactly once. A later write to row 1 leaves the outputs unchanged.
- R6: A write to a row that is already valid is rejected and sets `prog_err`. `prog_err` stays high until reset.
- R7: In frequency-select mode (`fs_mode`=1), `fs_sel`=0 selects row 0 and `fs_sel`=1 selects row 1. If the selected row is not valid, the block falls back to the shadow copy, or to the default when the shadow is off.
- R8: When no copy can be selected, the outputs carry an all-zero configuration and `active_src`=0.
- R9: In frequency-select mode, `pm_oe_mode` and `pm_sync_mode` are driven to 0 whatever the stored row holds.
- R10: The outputs are registered. A change of `fs_sel` appears after the next rising edge. A write stored at edge N appears after edge N+1.
- R11: While reset is asserted, all outputs are 0, `prog_err` is 0 and both rows are invalid. A `wr_sel` code of 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_mode | input | 1 | Strap: 1 = frequency-select mode, 0 = reprogram mode |
| shadow_off | input | 1 | Strap: disables the shadow copy |
| fs_sel | input | 1 | Frequency select (used in frequency-select mode) |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 shadow, 1 row 0, 2 row 1, 3 none |
| wr_data | input | 36 | Configuration word |
| fb_count | output | 12 | Feedback count |
| ref_count | output | 10 | Reference count |
| post_div | output | 3 | Post-divider select |
| div_src_pll | output | 1 | Divider source: 1 = PLL, 0 = oscillator |
| cap_tune | output | 7 | Load-capacitor tuning bits |
| duty_cmos | output | 1 | Duty level: 1 = CMOS, 0 = TTL |
| pm_oe_mode | output | 1 | Power-management mode: 1 = output enable, 0 = power down |
| pm_sync_mode | output | 1 | Power-management timing: 1 = synchronous |
| active_src | output | 2 | Active copy: 0 default, 1 shadow, 2 row 0, 3 row 1 |
| prog_err | output | 1 | Sticky flag for a rejected row write |

## Verification
The hardest situation to reach is a frequency-select configuration where the selected row is unburned while the other row is burned. Only in that case does the fallback path run at the same time as power-field masking. The stimulus reaches it by resetting into frequency-select mode with `fs_sel` high. It then burns row 0 only, checks that the shadow copy is still active, and then burns row 1 and toggles `fs_sel`. A second hard case is a rejected burn hidden behind an unchanged output. It is reached by rewriting each valid row with a different word and checking both the outputs and the sticky flag.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;
    localparam int FB_W    = 12;
    localparam int REF_W   = 10;
    localparam int POST_W  = 3;
    localparam int TUNE_W  = 7;
    localparam int NUM_ROWS = 2;
    localparam int CFG_W   = FB_W + REF_W + POST_W + 1 + TUNE_W + 3;
    localparam int SEL_W   = $clog2(NUM_ROWS + 2);

    // First member sits in the most significant bits.
    typedef struct packed {
        logic              pm_sync;
        logic              pm_oe;
        logic              duty_cmos;
        logic [TUNE_W-1:0] tune;
        logic              src_pll;
        logic [POST_W-1:0] post;
        logic [REF_W-1:0]  ref_cnt;
        logic [FB_W-1:0]   fb;
    } cfg_t;

    typedef enum logic [1:0] {
        SRC_DEF    = 2'd0,
        SRC_SHADOW = 2'd1,
        SRC_ROW0   = 2'd2,
        SRC_ROW1   = 2'd3
    } src_e;

    localparam logic [SEL_W-1:0] WR_SHADOW = '0;
endpackage

// File: rtl/cfg_store.sv
module cfg_store
    import cfgsel_pkg::*;
#(
    parameter int ROWS = NUM_ROWS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  cfg_t                  wr_data,
    output cfg_t                  shadow_o,
    output cfg_t [ROWS-1:0]       rows_o,
    output logic [ROWS-1:0]       valid_o,
    output logic                  err_o
);
    typedef struct packed {
        cfg_t                  shadow;
        cfg_t [ROWS-1:0]       rows;
        logic [ROWS-1:0]       valid;
        logic                  err;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_sel == WR_SHADOW) begin
                st_d.shadow = wr_data;
            end
            for (int r = 0; r < ROWS; r++) begin
                if (wr_sel == SEL_W'(r + 1)) begin
                    if (st_q.valid[r]) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.rows[r]  = wr_data;
                        st_d.valid[r] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow_o = st_q.shadow;
    assign rows_o   = st_q.rows;
    assign valid_o  = st_q.valid;
    assign err_o    = st_q.err;

    // R6: error flag never clears outside reset
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

    for (genvar g = 0; g < ROWS; g++) begin : g_row_chk
        // R5: a burned row keeps its contents
        assert_row_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.valid[g] |=> $stable(st_q.rows[g]));
        // R6: valid flag is one-way
        assert_valid_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.valid[g] |=> st_q.valid[g]);
    end
endmodule

// File: rtl/cfg_pick.sv
module cfg_pick
    import cfgsel_pkg::*;
#(
    parameter int ROWS = NUM_ROWS
) (
    input  logic             fs_mode,
    input  logic             fs_sel,
    input  logic             shadow_off,
    input  cfg_t             shadow_i,
    input  cfg_t [ROWS-1:0]  rows_i,
    input  logic [ROWS-1:0]  valid_i,
    output cfg_t             cfg_o,
    output src_e             src_o
);
    cfg_t fall_cfg;
    src_e fall_src;

    always_comb begin
        fall_cfg = shadow_off ? '0 : shadow_i;
        fall_src = shadow_off ? SRC_DEF : SRC_SHADOW;
        cfg_o    = fall_cfg;
        src_o    = fall_src;
        if (fs_mode) begin
            for (int r = 0; r < ROWS; r++) begin
                if (r == int'(fs_sel) && valid_i[r]) begin
                    cfg_o = rows_i[r];
                    src_o = src_e'(2'(int'(SRC_ROW0) + r));
                end
            end
            cfg_o.pm_oe   = 1'b0;
            cfg_o.pm_sync = 1'b0;
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                if (valid_i[r]) begin
                    cfg_o = rows_i[r];
                    src_o = src_e'(2'(int'(SRC_ROW0) + r));
                end
            end
        end
    end
endmodule

// File: rtl/cfg_row_selector.sv
module cfg_row_selector
    import cfgsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_mode,
    input  logic              shadow_off,
    input  logic              fs_sel,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [FB_W-1:0]   fb_count,
    output logic [REF_W-1:0]  ref_count,
    output logic [POST_W-1:0] post_div,
    output logic              div_src_pll,
    output logic [TUNE_W-1:0] cap_tune,
    output logic              duty_cmos,
    output logic              pm_oe_mode,
    output logic              pm_sync_mode,
    output logic [1:0]        active_src,
    output logic              prog_err
);
    typedef struct packed {
        cfg_t cfg;
        src_e src;
    } out_t;

    cfg_t                 shadow_w;
    cfg_t [NUM_ROWS-1:0]  rows_w;
    logic [NUM_ROWS-1:0]  valid_w;
    logic                 err_w;
    cfg_t                 pick_cfg;
    src_e                 pick_src;
    out_t                 out_d, out_q;

    cfg_store #(.ROWS(NUM_ROWS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (cfg_t'(wr_data)),
        .shadow_o (shadow_w),
        .rows_o   (rows_w),
        .valid_o  (valid_w),
        .err_o    (err_w)
    );

    cfg_pick #(.ROWS(NUM_ROWS)) u_pick (
        .fs_mode    (fs_mode),
        .fs_sel     (fs_sel),
        .shadow_off (shadow_off),
        .shadow_i   (shadow_w),
        .rows_i     (rows_w),
        .valid_i    (valid_w),
        .cfg_o      (pick_cfg),
        .src_o      (pick_src)
    );

    always_comb begin
        out_d     = out_q;
        out_d.cfg = pick_cfg;
        out_d.src = pick_src;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign fb_count     = out_q.cfg.fb;
    assign ref_count    = out_q.cfg.ref_cnt;
    assign post_div     = out_q.cfg.post;
    assign div_src_pll  = out_q.cfg.src_pll;
    assign cap_tune     = out_q.cfg.tune;
    assign duty_cmos    = out_q.cfg.duty_cmos;
    assign pm_oe_mode   = out_q.cfg.pm_oe;
    assign pm_sync_mode = out_q.cfg.pm_sync;
    assign active_src   = out_q.src;
    assign prog_err     = err_w;

    // R9: power fields masked one edge after frequency-select mode
    assert_pm_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fs_mode |=> (!pm_oe_mode && !pm_sync_mode));
    // R4: shadow strap keeps the shadow copy off the outputs
    assert_shadow_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_off |=> (active_src != SRC_SHADOW));
    // R8: default source always carries an all-zero word
    assert_default_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_src == SRC_DEF) |-> (out_q.cfg == '0));
    // R7: a burned selected row wins in frequency-select mode
    assert_fs_row1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_mode && fs_sel && valid_w[1]) |=> (active_src == SRC_ROW1));
    // R3: in reprogram mode a burned row 1 always wins
    assert_row1_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_mode && valid_w[1]) |=> (active_src == SRC_ROW1));
endmodule

// File: tb/tb_cfg_row_selector.sv
module tb_cfg_row_selector;
    import cfgsel_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, fs_mode, shadow_off, fs_sel, wr_en;
    logic [SEL_W-1:0] wr_sel;
    logic [CFG_W-1:0] wr_data;
    logic [FB_W-1:0] fb_count;
    logic [REF_W-1:0] ref_count;
    logic [POST_W-1:0] post_div;
    logic div_src_pll, duty_cmos, pm_oe_mode, pm_sync_mode, prog_err;
    logic [TUNE_W-1:0] cap_tune;
    logic [1:0] active_src;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_row_selector dut (.*);

    function automatic cfg_t mk(logic [11:0] fb, logic [9:0] rc, logic [2:0] pd,
                                logic sp, logic [6:0] tn, logic du, logic oe, logic sy);
        cfg_t c;
        c.fb = fb; c.ref_cnt = rc; c.post = pd; c.src_pll = sp;
        c.tune = tn; c.duty_cmos = du; c.pm_oe = oe; c.pm_sync = sy;
        return c;
    endfunction

    function automatic cfg_t pm_clear(cfg_t c);
        cfg_t r = c;
        r.pm_oe = 1'b0; r.pm_sync = 1'b0;
        return r;
    endfunction

    function automatic logic [CFG_W-1:0] word(cfg_t c);
        // R1 layout: fb[11:0] ref[21:12] post[24:22] src[25] tune[32:26] duty[33] oe[34] sync[35]
        return {c.pm_sync, c.pm_oe, c.duty_cmos, c.tune, c.src_pll, c.post, c.ref_cnt, c.fb};
    endfunction

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(string tag, cfg_t exp_c, logic [1:0] exp_s);
        cfg_t act;
        act = mk(fb_count, ref_count, post_div, div_src_pll, cap_tune,
                 duty_cmos, pm_oe_mode, pm_sync_mode);
        total++;
        if (act !== exp_c || active_src !== exp_s) begin
            bad++;
            $display("FAIL %s: cfg=%h src=%0d expected cfg=%h src=%0d",
                     tag, act, active_src, exp_c, exp_s);
        end
    endtask

    task automatic chk_err(string tag, logic exp_e);
        total++;
        if (prog_err !== exp_e) begin
            bad++;
            $display("FAIL %s: prog_err=%b expected %b", tag, prog_err, exp_e);
        end
    endtask

    task automatic write(logic [SEL_W-1:0] sel, cfg_t c);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = word(c);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    endtask

    task automatic do_reset(logic fsm, logic soff, logic fsv);
        @(negedge clk);
        rst_n = 1'b0; fs_mode = fsm; shadow_off = soff; fs_sel = fsv;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        tick(2);
        chk("R11 reset outputs", '0, 2'd0);
        chk_err("R11 reset error flag", 1'b0);
        rst_n = 1'b1;
        tick(1);
    endtask

    cfg_t ca, cb, cc, cd, ce, cf, cg, ch, ck;

    task automatic t_shadow();
        chk("R2 shadow active after reset", '0, 2'd1);
        write(2'd0, ca);
        chk("R10 write not yet visible", '0, 2'd1);
        tick(1);
        chk("R2 shadow first value", ca, 2'd1);
        write(2'd0, cb);
        tick(1);
        chk("R2 shadow rewritten", cb, 2'd1);
    endtask

    task automatic t_row0();
        write(2'd1, cc);
        tick(1);
        chk("R3 row0 active", cc, 2'd2);
        total++;
        if (fb_count !== 12'h5A3 || ref_count !== 10'h2F1 || cap_tune !== 7'h4B) begin
            bad++;
            $display("FAIL R1 field decode: fb=%h ref=%h tune=%h expected 5a3 2f1 4b",
                     fb_count, ref_count, cap_tune);
        end
        write(2'd0, cd);
        tick(1);
        chk("R2 shadow write ignored once row valid", cc, 2'd2);
        chk_err("R6 no error yet", 1'b0);
    endtask

    task automatic t_reject();
        write(2'd1, ce);
        tick(1);
        chk("R6 rewrite of row0 rejected", cc, 2'd2);
        chk_err("R6 error raised", 1'b1);
    endtask

    task automatic t_row1();
        write(2'd2, cf);
        tick(1);
        chk("R5 row1 replaces row0", cf, 2'd3);
        chk_err("R6 error stays sticky", 1'b1);
        write(2'd2, cg);
        tick(1);
        chk("R5 second row1 write rejected", cf, 2'd3);
        write(2'd3, cg);
        tick(1);
        chk("R11 wr_sel 3 writes nothing", cf, 2'd3);
    endtask

    task automatic t_shadow_off();
        do_reset(1'b0, 1'b1, 1'b0);
        chk("R8 default when nothing selectable", '0, 2'd0);
        write(2'd0, ca);
        tick(1);
        chk("R4 shadow write has no effect", '0, 2'd0);
        chk_err("R6 clean after reset", 1'b0);
        write(2'd1, cc);
        tick(1);
        chk("R4 row drives with shadow off", cc, 2'd2);
    endtask

    task automatic t_fs();
        do_reset(1'b1, 1'b0, 1'b1);
        write(2'd0, cb);
        write(2'd1, ch);
        tick(1);
        chk("R7 unburned row1 falls back to shadow", pm_clear(cb), 2'd1);
        write(2'd2, ck);
        tick(1);
        chk("R7 fs=1 selects row1", pm_clear(ck), 2'd3);
        chk("R9 power fields masked", pm_clear(ck), 2'd3);
        fs_sel = 1'b0;
        #1;
        chk("R10 fs change waits for edge", pm_clear(ck), 2'd3);
        tick(1);
        chk("R7 fs=0 selects row0", pm_clear(ch), 2'd2);
        write(2'd2, ca);
        tick(1);
        chk_err("R6 reject in frequency-select mode", 1'b1);
        fs_sel = 1'b1;
        tick(1);
        chk("R5 row1 kept after rejected write", pm_clear(ck), 2'd3);
    endtask

    task automatic t_fs_nosh();
        do_reset(1'b1, 1'b1, 1'b1);
        write(2'd1, ch);
        tick(1);
        chk("R7 unburned row1 falls back to default", '0, 2'd0);
    endtask

    bit finished = 1'b0;

    initial begin
        ca = mk(12'h111, 10'h011, 3'd1, 1'b1, 7'h01, 1'b0, 1'b1, 1'b0);
        cb = mk(12'hFFF, 10'h3FF, 3'd7, 1'b0, 7'h7F, 1'b1, 1'b1, 1'b1);
        cc = mk(12'h5A3, 10'h2F1, 3'd4, 1'b1, 7'h4B, 1'b1, 1'b0, 1'b1);
        cd = mk(12'h002, 10'h004, 3'd2, 1'b0, 7'h10, 1'b0, 1'b0, 1'b0);
        ce = mk(12'hABC, 10'h155, 3'd3, 1'b0, 7'h2A, 1'b0, 1'b1, 1'b1);
        cf = mk(12'h800, 10'h200, 3'd6, 1'b1, 7'h40, 1'b0, 1'b1, 1'b0);
        cg = mk(12'h0F0, 10'h0F0, 3'd5, 1'b1, 7'h33, 1'b1, 1'b0, 1'b0);
        ch = mk(12'h321, 10'h123, 3'd0, 1'b1, 7'h55, 1'b1, 1'b1, 1'b1);
        ck = mk(12'h789, 10'h0AB, 3'd2, 1'b0, 7'h0C, 1'b0, 1'b1, 1'b1);
        rst_n = 1'b0; fs_mode = 1'b0; shadow_off = 1'b0; fs_sel = 1'b0;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        do_reset(1'b0, 1'b0, 1'b0);
        t_shadow();
        t_row0();
        t_reject();
        t_row1();
        t_shadow_off();
        t_fs();
        t_fs_nosh();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule